// File: doc/BRIEF.md
# Vectored Interrupt Channel Manager

This block sits between the interrupt sources of a chip and a processor that has two interrupt inputs: a fast one and a normal one. Each of up to 128 level-sensitive request lines is steered onto a numbered channel through a programmable byte-wide map. Each channel has an enable bit and a class bit, and the class bit picks the fast or the normal output.

For each class the block reports the lowest-numbered pending enabled channel as an index register holding channel plus one, with zero meaning idle. A flag per class goes high whenever that index is nonzero. Channels 0 and 1 are fixed system channels. They always map to requests 0 and 1, are always enabled and always fast. Software configures the rest through a word-addressed synchronous register bus. Writes take effect at the clock edge, and reads are combinational.

Top module: `vic_chan_mgr`

## Requirements
- R1: Channel c is raised when request number map[c] is high. map[c] is 8 bits. Channel-control word at address 0x40+i holds channels 4i..4i+3, with channel 4i in bits 31:24, 4i+1 in 23:16, 4i+2 in 15:8 and 4i+3 in 7:0. A map value of NUM_REQ or more selects no request. After reset, map[c] = c.
- R2: Enable bits are written through set words at 0x08+k and clear words at 0x10+k. Channel n is bit n%32 of word n/32. A 1 bit sets (set word) or clears (clear word) that enable, and 0 bits change nothing. Both addresses read back the current enables.
- R3: Class words at 0x00+k use the same bit layout. A bit of 1 sends the channel to the fast class, and 0 sends it to the normal class.
- R4: Channels 0 and 1 ignore all map, class and enable writes. They stay mapped to requests 0 and 1, enabled, and in the fast class.
- R5: The fast index (read at 0x18) and the normal index (read at 0x19) each hold the lowest-numbered pending enabled channel of that class plus one, or 0 when none is pending.
- R6: The indexes and flags change at the first rising clock edge after a change on the request lines or in the configuration, and not before that edge.
- R7: fiq_req is high exactly when the fast index is nonzero, and irq_req is high exactly when the normal index is nonzero.
- R8: The capture register at 0x1A stores two 7-bit channel selectors in bits 6:0 and 22:16. All other bits read 0.
- R9: After reset, channels 2 and up are disabled and in the normal class, both indexes and flags are 0, and the capture register is 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_REQ | Level request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| fiq_req | output | 1 | Fast class has a pending channel |
| irq_req | output | 1 | Normal class has a pending channel |
| fiq_index | output | $clog2(NUM_CH+1) | Fast pending channel plus one |
| irq_index | output | $clog2(NUM_CH+1) | Normal pending channel plus one |

## Verification
The bench remaps one channel onto a high request number and checks two things. The remapped channel answers to the new request, and nothing answers to the old one. A crossbar that indexed by channel instead of by map entry would report a pending channel where there should be none. Several channels are raised at once, including across 32-bit word borders and across both classes, to catch a priority encoder that favours high numbers or drops the plus-one offset. The bench also writes all-ones to the reserved channels' map, class and clear bits and out-of-range map values, since a design that lets those writes through loses the system channel or reads a stray request. Single-bit clear writes check that the zero bits of a clear word leave the other enables alone.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
   localparam int AW     = 7;   // word address width
   localparam int DW     = 32;  // bus data width
   localparam int SEL_W  = 8;   // request number width in a map entry
   localparam int A_TYPE = 'h00;
   localparam int A_SET  = 'h08;
   localparam int A_CLR  = 'h10;
   localparam int A_FIQ  = 'h18;
   localparam int A_IRQ  = 'h19;
   localparam int A_CAP  = 'h1A;
   localparam int A_CC   = 'h40;
   localparam int N_SYS  = 2;   // fixed system channels
endpackage

// File: rtl/vcm_xbar.sv
module vcm_xbar import vcm_pkg::*; #(
   parameter int NUM_CH  = 128,
   parameter int NUM_REQ = 128
) (
   input  logic [NUM_REQ-1:0]            req,
   input  logic [NUM_CH-1:0][SEL_W-1:0]  sel,
   output logic [NUM_CH-1:0]             hit
);
   localparam int PAD = 1 << SEL_W;

   // request numbers at or above NUM_REQ land on zero padding
   logic [PAD-1:0] req_pad;
   assign req_pad = PAD'(req);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = req_pad[sel[c]];
   end
endmodule

// File: rtl/vcm_prio.sv
module vcm_prio #(
   parameter int N  = 128,
   parameter int IW = $clog2(N + 1)
) (
   input  logic [N-1:0]  pend,
   output logic [IW-1:0] idx
);
   // lowest channel wins; result is channel plus one, zero when idle
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IW'(i + 1);
      end
   end
endmodule

// File: rtl/vcm_cfg.sv
module vcm_cfg import vcm_pkg::*; #(
   parameter int NUM_CH = 128,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [AW-1:0]                 addr,
   input  logic [DW-1:0]                 wdata,
   output logic [NUM_CH-1:0]             en_o,
   output logic [NUM_CH-1:0]             fast_o,
   output logic [NUM_CH-1:0][SEL_W-1:0]  map_o,
   output logic [CH_W-1:0]               cap0_o,
   output logic [CH_W-1:0]               cap1_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int W  = c / 32;
      localparam int B  = c % 32;
      localparam int CW = c / 4;
      localparam int SH = 8 * (3 - (c % 4));
      if (c < N_SYS) begin : g_sys
         assign en_o[c]   = 1'b1;
         assign fast_o[c] = 1'b1;
         assign map_o[c]  = SEL_W'(c);
      end else begin : g_user
         logic                en_r, ty_r;
         logic [SEL_W-1:0]    mp_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_r <= 1'b0;
               ty_r <= 1'b0;
               mp_r <= SEL_W'(c);
            end else if (wr) begin
               if (addr == AW'(A_TYPE + W)) ty_r <= wdata[B];
               if (addr == AW'(A_SET + W) && wdata[B]) en_r <= 1'b1;
               if (addr == AW'(A_CLR + W) && wdata[B]) en_r <= 1'b0;
               if (addr == AW'(A_CC + CW)) mp_r <= wdata[SH +: SEL_W];
            end
         end
         assign en_o[c]   = en_r;
         assign fast_o[c] = ty_r;
         assign map_o[c]  = mp_r;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap0_o <= '0;
         cap1_o <= '0;
      end else if (wr && addr == AW'(A_CAP)) begin
         cap0_o <= wdata[0 +: CH_W];
         cap1_o <= wdata[16 +: CH_W];
      end
   end
endmodule

// File: rtl/vic_chan_mgr.sv
module vic_chan_mgr import vcm_pkg::*; #(
   parameter int NUM_CH  = 128,
   parameter int NUM_REQ = 128,
   localparam int IW     = $clog2(NUM_CH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_in,
   input  logic               reg_wr,
   input  logic [AW-1:0]      reg_addr,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   output logic               fiq_req,
   output logic               irq_req,
   output logic [IW-1:0]      fiq_index,
   output logic [IW-1:0]      irq_index
);
   localparam int CH_W  = $clog2(NUM_CH);
   localparam int NWORD = NUM_CH / 32;
   localparam int NCW   = NUM_CH / 4;

   if (NUM_CH % 32 != 0 || NUM_CH < 32 || NUM_CH > 256) begin : g_bad_ch
      $error("NUM_CH must be a multiple of 32 in 32..256");
   end
   if (NUM_REQ < 1 || NUM_REQ > 256) begin : g_bad_req
      $error("NUM_REQ must be in 1..256");
   end

   logic [NUM_CH-1:0]            en_v, fast_v, hit_v, pend_fast, pend_norm;
   logic [NUM_CH-1:0][SEL_W-1:0] map_v;
   logic [CH_W-1:0]              cap0, cap1;
   logic [IW-1:0]                fiq_nx, irq_nx;

   vcm_cfg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .en_o(en_v), .fast_o(fast_v), .map_o(map_v), .cap0_o(cap0), .cap1_o(cap1)
   );

   vcm_xbar #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) i_xbar (
      .req(req_in), .sel(map_v), .hit(hit_v)
   );

   assign pend_fast = hit_v & en_v & fast_v;
   assign pend_norm = hit_v & en_v & ~fast_v;

   vcm_prio #(.N(NUM_CH), .IW(IW)) i_prio_fast (.pend(pend_fast), .idx(fiq_nx));
   vcm_prio #(.N(NUM_CH), .IW(IW)) i_prio_norm (.pend(pend_norm), .idx(irq_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fiq_index <= '0;
         irq_index <= '0;
         fiq_req   <= 1'b0;
         irq_req   <= 1'b0;
      end else begin
         fiq_index <= fiq_nx;
         irq_index <= irq_nx;
         fiq_req   <= |pend_fast;
         irq_req   <= |pend_norm;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NWORD; w++) begin
         if (reg_addr == AW'(A_TYPE + w)) reg_rdata = fast_v[w*32 +: 32];
         if (reg_addr == AW'(A_SET + w) || reg_addr == AW'(A_CLR + w))
            reg_rdata = en_v[w*32 +: 32];
      end
      for (int w = 0; w < NCW; w++) begin
         if (reg_addr == AW'(A_CC + w)) begin
            for (int j = 0; j < 4; j++) reg_rdata[8*(3-j) +: 8] = map_v[4*w + j];
         end
      end
      if (reg_addr == AW'(A_FIQ)) reg_rdata = DW'(fiq_index);
      if (reg_addr == AW'(A_IRQ)) reg_rdata = DW'(irq_index);
      if (reg_addr == AW'(A_CAP)) begin
         reg_rdata[0 +: CH_W]  = cap0;
         reg_rdata[16 +: CH_W] = cap1;
      end
   end
endmodule

// File: rtl/vcm_checker.sv
module vcm_checker import vcm_pkg::*; #(
   parameter int NUM_CH  = 128,
   parameter int NUM_REQ = 128,
   localparam int IW     = $clog2(NUM_CH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] req_in,
   input logic               reg_wr,
   input logic [AW-1:0]      reg_addr,
   input logic [DW-1:0]      reg_wdata,
   input logic               fiq_req,
   input logic               irq_req,
   input logic [IW-1:0]      fiq_index,
   input logic [IW-1:0]      irq_index
);
   // cycles since reset, saturating at 2
   logic [1:0] pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 2'd0;
      else if (pv != 2'd2) pv <= pv + 2'd1;
   end

   a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_index <= IW'(NUM_CH) && irq_index <= IW'(NUM_CH));

   a_r3_class_split: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_index != '0) |-> (fiq_index != irq_index));

   a_r4_sys_channel_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (pv != 2'd0 && $past(req_in[0])) |-> (fiq_index == IW'(1)));

   a_r6_idle_follows_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pv != 2'd0 && $past(req_in) == '0) |-> (fiq_index == '0 && irq_index == '0));

   a_r7_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req == (fiq_index != '0)) && (irq_req == (irq_index != '0)));

   a_r2_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (pv == 2'd2 && $past(reg_wr && reg_addr == AW'(A_CLR) && reg_wdata[2], 2))
      |-> (fiq_index != IW'(3) && irq_index != IW'(3)));
endmodule

bind vic_chan_mgr vcm_checker #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) i_vcm_checker (.*);

// File: tb/test_vic_chan_mgr.sv
module test_vic_chan_mgr;
   localparam int CLK_P = 10;
   localparam int NV    = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] req_in = '0;
   logic         reg_wr = 1'b0;
   logic [6:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         fiq_req, irq_req;
   logic [7:0]   fiq_index, irq_index;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   vic_chan_mgr i_vic_chan_mgr (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fiq_req(fiq_req), .irq_req(irq_req),
      .fiq_index(fiq_index), .irq_index(irq_index)
   );

   // vectors with: all enabled, channels 0,1,5 fast, channel 4 mapped to request 100
   localparam logic [127:0] V_REQ [NV] = '{
      128'd0,
      128'd1 << 3,
      128'd1 << 5,
      (128'd1 << 0) | (128'd1 << 3),
      128'd1 << 100,
      128'd1 << 4,
      128'd1 << 127,
      (128'd1 << 1) | (128'd1 << 5) | (128'd1 << 127),
      (128'd1 << 64) | (128'd1 << 70),
      (128'd1 << 31) | (128'd1 << 32),
      (128'd1 << 2) | (128'd1 << 100)
   };
   localparam int V_FIQ [NV] = '{0, 0, 6, 1, 0, 0, 0,   2, 0,  0,  0};
   localparam int V_IRQ [NV] = '{0, 4, 0, 4, 5, 0, 128, 128, 65, 32, 3};

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 7'(a);
      #1 d = reg_rdata;
   endtask

   // drive requests, then sample one edge later
   task automatic apply(input logic [127:0] r, input string tag, input int ef, input int ei);
      @(negedge clk);
      req_in = r;
      @(negedge clk);
      chk({tag, " fast index"}, fiq_index, ef);
      chk({tag, " normal index"}, irq_index, ei);
      chk({tag, " R7 fast flag"}, fiq_req, ef != 0);
      chk({tag, " R7 normal flag"}, irq_req, ei != 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      chk("R9 fast index", fiq_index, 0);
      chk("R9 normal index", irq_index, 0);
      chk("R9 flags", {fiq_req, irq_req}, 0);
      rd('h00, d); chk("R9 class word0", d, 32'h3);
      rd('h08, d); chk("R9 enable word0", d, 32'h3);
      rd('h09, d); chk("R9 enable word1", d, 32'h0);
      rd('h1A, d); chk("R9 capture", d, 32'h0);
      rd('h7F, d); chk("R9 unmapped", d, 32'h0);
      rd('h40, d); chk("R1 map word0 reset", d, 32'h00010203);
      rd('h5F, d); chk("R1 map word31 reset", d, 32'h7C7D7E7F);

      // configuration
      for (int k = 0; k < 4; k++) wr('h08 + k, 32'hFFFF_FFFF);
      wr('h00, 32'h0000_0020);
      wr('h41, 32'h6405_0607);
      rd('h10, d); chk("R2 readback via clear word0", d, 32'hFFFF_FFFF);
      rd('h41, d); chk("R1 map word1 readback", d, 32'h6405_0607);

      // vector table: R1 R3 R5
      for (int v = 0; v < NV; v++) apply(V_REQ[v], $sformatf("R5 vec%0d", v), V_FIQ[v], V_IRQ[v]);

      // R4: reserved channels survive clear, class and map writes
      wr('h10, 32'hFFFF_FFFF);
      rd('h08, d); chk("R4 enables after clear-all", d, 32'h3);
      apply((128'd1 << 0) | (128'd1 << 3), "R4 sys channel", 1, 0);
      wr('h08, 32'hFFFF_FFFF);
      wr('h00, 32'h0);
      rd('h00, d); chk("R4 class word0", d, 32'h3);
      wr('h40, 32'hFFFF_FFFF);
      rd('h40, d); chk("R4 map word0", d, 32'h0001FFFF);
      apply((128'd1 << 2) | (128'd1 << 3), "R1 out-of-range map", 0, 0);
      wr('h40, 32'h0001_0203);

      // R2: single-bit clear leaves neighbours alone
      wr('h10, 32'h0000_0008);
      rd('h08, d); chk("R2 enables after clearing ch3", d, 32'hFFFF_FFF7);
      apply(128'd1 << 3, "R2 masked ch3", 0, 0);
      apply((128'd1 << 2) | (128'd1 << 3), "R2 ch2 kept", 0, 3);
      wr('h09, 32'h0);
      rd('h09, d); chk("R2 zero set word", d, 32'hFFFF_FFFF);

      // R3: class change moves channel 2 to the fast output
      wr('h00, 32'h0000_0004);
      apply(128'd1 << 2, "R3 ch2 fast", 3, 0);

      // R6: no change before the edge, change after it
      @(negedge clk);
      req_in = 128'd1 << 127;
      #1 chk("R6 before edge", irq_index, 0);
      @(negedge clk);
      chk("R6 after edge", irq_index, 128);
      apply(128'd0, "R6 back to idle", 0, 0);

      // R8 capture selectors
      wr('h1A, 32'hFFFF_FFFF);
      rd('h1A, d); chk("R8 capture", d, 32'h007F_007F);
      rd('h18, d); chk("R5 fast index readback", d, 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule